// File: doc/BRIEF.md
# Delta-Sigma Converter Bring-Up and Streaming Sequencer

This block is the host side of a four-wire SPI link to an external 16-bit delta-sigma converter. It leaves reset, waits out the supply settling time, and resets the converter by command. It then waits out the converter's internal reset and, if enabled, polls the converter's status byte until it reports ready and clears that byte. After that it idles with `busy` low.

A `start_req` pulse makes it write a small block of configuration bytes, taken from `cfg_data`, into consecutive converter registers. It reads the same block back and compares every byte. Only when all bytes match does it send the command that begins continuous conversion. While streaming, each falling edge of the converter's active-low data-ready line makes it fetch one 16-bit result. The result is presented on `result` together with a one-cycle `result_valid` strobe.

A `stop_req` pulse sends the standby command and returns the block to idle. A readback mismatch raises a sticky `config_error`, and from then on the start command is never sent. Data-ready edges that arrive while a fetch is still in progress are counted on `overrun`.

Top module: `adc_seq_host`

## Requirements
- R1: From reset, `busy` is 1, `spi_cs_n` is 1, `result_valid` is 0, `config_error` is 0 and `overrun` is 0. No chip-select assertion occurs until 2.2 ms after reset. That time is counted in `clk` cycles as (CLK_HZ/10000)*22.
- R2: The SPI link uses mode 1. `spi_sclk` is 0 whenever `spi_cs_n` is 1. `spi_mosi` changes only on a rising `spi_sclk` edge and is stable while `spi_sclk` is high. `spi_miso` is sampled at the falling edge.
- R3: The first frame is the single byte 06h. The next frame does not begin until at least 4096*MOD_DIV cycles after that frame's chip-select release.
- R4: With STAT_CHECK=1, the block sends the frame 21h,00h,00h and takes the third returned byte as status. Bit 6 of that byte set to 1 means "not ready", and the read is then repeated. Once bit 6 is 0, the frame 41h,00h,00h clears the status byte and `busy` falls.
- R5: With `busy` low, `start_req` sends the frame (40h|CFG_BASE),(NUM_CFG-1),cfg byte 0..NUM_CFG-1. Byte i is `cfg_data[8i+7:8i]`. A `start_req` while `busy` is high is ignored.
- R6: The config write is followed by the readback frame (20h|CFG_BASE),(NUM_CFG-1) and NUM_CFG dummy 00h bytes. If every returned byte equals its config byte, the single-byte frame 08h follows.
- R7: Any readback mismatch sets `config_error`, which stays 1 until reset. In that case no 08h frame is sent and `busy` returns low. Later `start_req` pulses produce no frame.
- R8: While streaming, a falling edge of `adc_drdy_n` produces the frame 12h,00h,00h. The two returned bytes, MSB first, appear on `result` with `result_valid` high for exactly one cycle.
- R9: A falling edge of `adc_drdy_n` during a result fetch adds one to `overrun`, which saturates at its maximum. It causes no extra frame and no extra `result_valid`.
- R10: While streaming, `stop_req` waits for any fetch in progress to finish, then sends the single-byte frame 0Ah, and `busy` falls. A new `start_req` then repeats the R5/R6 sequence.
- R11: When `stop_req` and a data-ready falling edge reach the sequencer in the same cycle, the stop wins. The next frame is 0Ah, no result is produced, and `overrun` is unchanged.
- R12: Chip-select goes low at least TCSSC_CYC cycles before the first `spi_sclk` rise of a frame. It stays low at least TSCCS_CYC cycles after the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Pulse: configure, verify and begin streaming |
| stop_req | input | 1 | Pulse: end streaming and put converter in standby |
| cfg_data | input | NUM_CFG*8 | Configuration bytes, byte 0 in the low bits |
| busy | output | 1 | High except when idle and ready |
| result_valid | output | 1 | One-cycle strobe for `result` |
| result | output | 16 | Last fetched conversion result |
| config_error | output | 1 | Sticky readback mismatch flag |
| overrun | output | OVR_W | Saturating count of data-ready edges lost during a fetch |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |
| adc_drdy_n | input | 1 | Active-low data-ready from converter |

## Verification
A stop request and a data-ready falling edge can both arrive at the streaming decision point in the same cycle. The bench provokes this by pulling data-ready low and timing a one-cycle `stop_req` so that it lands in the same clock as the synchronized edge, two clocks later. It judges the result from the converter model's frame log and the outputs. The next frame must be the single byte 0Ah, `result_valid` must never rise, and `overrun` must be unchanged.

// File: rtl/adc_seq_pkg.sv
// Shared types and command bytes for the converter host sequencer.
package adc_seq_pkg;
    localparam logic [7:0] CMD_RESET = 8'h06;
    localparam logic [7:0] CMD_START = 8'h08;
    localparam logic [7:0] CMD_STOP  = 8'h0A;
    localparam logic [7:0] CMD_RDATA = 8'h12;
    localparam logic [2:0] OP_RREG   = 3'b001;
    localparam logic [2:0] OP_WREG   = 3'b010;
    localparam logic [4:0] STAT_ADDR = 5'h01;
    localparam int         NRDY_BIT  = 6;

    typedef enum logic [2:0] {
        S_IDLE, S_LEAD, S_RISE, S_HIGH, S_LOW, S_TRAIL, S_GAP
    } spi_st_t;

    typedef enum logic [3:0] {
        P_PWR, P_RST_TX, P_RST_WAIT, P_STAT_RD, P_STAT_CLR, P_READY,
        P_CFG_WR, P_CFG_RD, P_START_TX, P_STREAM, P_DATA_RD, P_STOP_TX
    } phase_t;
endpackage

// File: rtl/drdy_edge_det.sv
// Synchronizes the asynchronous active-low data-ready line and emits a
// one-cycle pulse on each falling edge. Assumes the line idles high.
module drdy_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n_in,
    output logic fall
);
    logic [2:0] sync_q;

    // Shift the line through a three-stage register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], drdy_n_in};
    end

    assign fall = sync_q[2] & ~sync_q[1];

    // R8
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/spi_frame_master.sv
// Mode-1 SPI frame engine: asserts chip select, shifts nbytes bytes
// MSB first (launch on SCLK rise, sample on SCLK fall), holds chip select,
// releases it and keeps a recovery gap before reporting done.
// Assumes the byte source (tx_byte for tx_idx) is combinational.
module spi_frame_master
    import adc_seq_pkg::*;
#(
    parameter int TCSSC = 2,
    parameter int TSCCS = 2,
    parameter int HALF  = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IDX_W-1:0] nbytes,
    input  logic [7:0]       tx_byte,
    output logic [IDX_W-1:0] tx_idx,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [IDX_W-1:0] rx_idx,
    output logic             done,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    localparam int CMAX  = (TCSSC > TSCCS) ? ((TCSSC > HALF) ? TCSSC : HALF)
                                           : ((TSCCS > HALF) ? TSCCS : HALF);
    localparam int CNT_W = $clog2(CMAX + 1);

    spi_st_t          st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_i;
    logic [7:0]       sh;
    logic [IDX_W-1:0] byte_i;
    logic [IDX_W-1:0] last_i;

    assign tx_idx = byte_i;

    // Frame state machine with per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;  cnt <= '0;  bit_i <= 3'd7;  sh <= '0;
            byte_i <= '0;  last_i <= '0;
            cs_n <= 1'b1;  sclk <= 1'b0;  mosi <= 1'b0;
            rx_valid <= 1'b0;  rx_data <= '0;  rx_idx <= '0;  done <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            done     <= 1'b0;
            case (st)
                S_IDLE: if (go) begin
                    cs_n   <= 1'b0;
                    cnt    <= CNT_W'(TCSSC - 1);
                    byte_i <= '0;
                    bit_i  <= 3'd7;
                    last_i <= nbytes - 1'b1;
                    st     <= S_LEAD;
                end
                S_LEAD: if (cnt == 0) st <= S_RISE; else cnt <= cnt - 1'b1;
                S_RISE: begin
                    sclk <= 1'b1;
                    mosi <= tx_byte[bit_i];
                    cnt  <= CNT_W'(HALF - 1);
                    st   <= S_HIGH;
                end
                S_HIGH: if (cnt == 0) begin
                    sclk <= 1'b0;
                    sh   <= {sh[6:0], miso};
                    cnt  <= CNT_W'(HALF - 1);
                    st   <= S_LOW;
                end else cnt <= cnt - 1'b1;
                S_LOW: if (cnt == 0) begin
                    if (bit_i == 0) begin
                        rx_valid <= 1'b1;
                        rx_data  <= sh;
                        rx_idx   <= byte_i;
                        if (byte_i == last_i) begin
                            cnt <= CNT_W'(TSCCS - 1);
                            st  <= S_TRAIL;
                        end else begin
                            byte_i <= byte_i + 1'b1;
                            bit_i  <= 3'd7;
                            st     <= S_RISE;
                        end
                    end else begin
                        bit_i <= bit_i - 1'b1;
                        st    <= S_RISE;
                    end
                end else cnt <= cnt - 1'b1;
                S_TRAIL: if (cnt == 0) begin
                    cs_n <= 1'b1;
                    cnt  <= CNT_W'(TCSSC - 1);
                    st   <= S_GAP;
                end else cnt <= cnt - 1'b1;
                S_GAP: if (cnt == 0) begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end else cnt <= cnt - 1'b1;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R2
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/adc_seq_host.sv
// Host sequencer for an external 16-bit delta-sigma converter: power-up
// wait, reset command, optional status poll/clear, configuration write and
// readback compare, start, data-ready driven result fetches, stop.
// Assumes cfg_data is stable from start_req until busy falls.
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int         CLK_HZ     = 50_000_000,
    parameter int         MOD_DIV    = 12,
    parameter int         TCSSC_CYC  = 2,
    parameter int         TSCCS_CYC  = 2,
    parameter int         SCLK_HALF  = 4,
    parameter int         NUM_CFG    = 4,
    parameter logic [4:0] CFG_BASE   = 5'h02,
    parameter bit         STAT_CHECK = 1'b1,
    parameter int         OVR_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_req,
    input  logic                 stop_req,
    input  logic [NUM_CFG*8-1:0] cfg_data,
    output logic                 busy,
    output logic                 result_valid,
    output logic [15:0]          result,
    output logic                 config_error,
    output logic [OVR_W-1:0]     overrun,
    output logic                 spi_cs_n,
    output logic                 spi_sclk,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    input  logic                 adc_drdy_n
);
    localparam int PWR_CYC = (CLK_HZ / 10000) * 22;
    localparam int RST_CYC = 4096 * MOD_DIV;
    localparam int WMAX    = (PWR_CYC > RST_CYC) ? PWR_CYC : RST_CYC;
    localparam int WAIT_W  = $clog2(WMAX + 1);
    localparam int MAXB    = NUM_CFG + 2;
    localparam int IDX_W   = $clog2(MAXB + 1);

    phase_t            ph;
    logic              sent, stop_pend, mism, nrdy;
    logic [WAIT_W-1:0] wcnt;
    logic [7:0]        hi_byte, tx_byte, rx_data, cfg_tx, cfg_rx;
    logic [IDX_W-1:0]  nbytes, tx_idx, rx_idx;
    logic              xfer_go, xfer_done, rx_valid, drdy_fall, frame_ph;

    drdy_edge_det u_drdy (
        .clk(clk), .rst_n(rst_n), .drdy_n_in(adc_drdy_n), .fall(drdy_fall)
    );

    spi_frame_master #(
        .TCSSC(TCSSC_CYC), .TSCCS(TSCCS_CYC), .HALF(SCLK_HALF), .IDX_W(IDX_W)
    ) u_spi (
        .clk(clk), .rst_n(rst_n), .go(xfer_go), .nbytes(nbytes),
        .tx_byte(tx_byte), .tx_idx(tx_idx), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_idx(rx_idx), .done(xfer_done),
        .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    assign frame_ph = ph inside {P_RST_TX, P_STAT_RD, P_STAT_CLR, P_CFG_WR,
                                 P_CFG_RD, P_START_TX, P_DATA_RD, P_STOP_TX};
    assign xfer_go  = frame_ph && !sent;
    assign busy     = (ph != P_READY);

    // Pick the configuration bytes addressed by the transmit and receive indices.
    always_comb begin
        cfg_tx = 8'h00;
        cfg_rx = 8'h00;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (32'(tx_idx) == i + 2) cfg_tx = cfg_data[8*i +: 8];
            if (32'(rx_idx) == i + 2) cfg_rx = cfg_data[8*i +: 8];
        end
    end

    // Frame length and outgoing byte for the current phase.
    always_comb begin
        nbytes  = IDX_W'(1);
        tx_byte = 8'h00;
        case (ph)
            P_RST_TX:   tx_byte = CMD_RESET;
            P_START_TX: tx_byte = CMD_START;
            P_STOP_TX:  tx_byte = CMD_STOP;
            P_STAT_RD: begin
                nbytes = IDX_W'(3);
                if (tx_idx == 0) tx_byte = {OP_RREG, STAT_ADDR};
            end
            P_STAT_CLR: begin
                nbytes = IDX_W'(3);
                if (tx_idx == 0) tx_byte = {OP_WREG, STAT_ADDR};
            end
            P_DATA_RD: begin
                nbytes = IDX_W'(3);
                if (tx_idx == 0) tx_byte = CMD_RDATA;
            end
            P_CFG_WR, P_CFG_RD: begin
                nbytes = IDX_W'(MAXB);
                if (tx_idx == 0)      tx_byte = {(ph == P_CFG_WR) ? OP_WREG : OP_RREG, CFG_BASE};
                else if (tx_idx == 1) tx_byte = 8'(NUM_CFG - 1);
                else if (ph == P_CFG_WR) tx_byte = cfg_tx;
            end
            default: ;
        endcase
    end

    // Bring-up script, streaming loop and result/flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= P_PWR;  wcnt <= WAIT_W'(PWR_CYC - 1);
            sent <= 1'b0;  stop_pend <= 1'b0;  mism <= 1'b0;  nrdy <= 1'b0;
            hi_byte <= '0;  result <= '0;  result_valid <= 1'b0;
            config_error <= 1'b0;  overrun <= '0;
        end else begin
            result_valid <= 1'b0;
            if (xfer_go)   sent <= 1'b1;
            if (xfer_done) sent <= 1'b0;
            if (stop_req && (ph inside {P_START_TX, P_STREAM, P_DATA_RD}))
                stop_pend <= 1'b1;
            if (ph == P_DATA_RD && drdy_fall && overrun != '1)
                overrun <= overrun + 1'b1;
            if (rx_valid) begin
                if (ph == P_STAT_RD && rx_idx == 2) nrdy <= rx_data[NRDY_BIT];
                if (ph == P_CFG_RD && rx_idx >= 2 && rx_data != cfg_rx) mism <= 1'b1;
                if (ph == P_DATA_RD && rx_idx == 1) hi_byte <= rx_data;
                if (ph == P_DATA_RD && rx_idx == 2) begin
                    result       <= {hi_byte, rx_data};
                    result_valid <= 1'b1;
                end
            end
            case (ph)
                P_PWR:      if (wcnt == 0) ph <= P_RST_TX; else wcnt <= wcnt - 1'b1;
                P_RST_TX:   if (xfer_done) begin
                    ph   <= P_RST_WAIT;
                    wcnt <= WAIT_W'(RST_CYC - 1);
                end
                P_RST_WAIT: if (wcnt == 0) ph <= STAT_CHECK ? P_STAT_RD : P_READY;
                            else wcnt <= wcnt - 1'b1;
                P_STAT_RD:  if (xfer_done && !nrdy) ph <= P_STAT_CLR;
                P_STAT_CLR: if (xfer_done) ph <= P_READY;
                P_READY:    if (start_req && !config_error) begin
                    ph   <= P_CFG_WR;
                    mism <= 1'b0;
                end
                P_CFG_WR:   if (xfer_done) ph <= P_CFG_RD;
                P_CFG_RD:   if (xfer_done) begin
                    if (mism) begin
                        config_error <= 1'b1;
                        ph           <= P_READY;
                    end else ph <= P_START_TX;
                end
                P_START_TX: if (xfer_done) ph <= P_STREAM;
                P_STREAM: begin
                    if (stop_pend || stop_req) begin
                        stop_pend <= 1'b0;
                        ph        <= P_STOP_TX;
                    end else if (drdy_fall) ph <= P_DATA_RD;
                end
                P_DATA_RD:  if (xfer_done) ph <= P_STREAM;
                P_STOP_TX:  if (xfer_done) begin
                    stop_pend <= 1'b0;
                    ph        <= P_READY;
                end
                default:    ph <= P_READY;
            endcase
        end
    end

    // R1
    pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == P_PWR) |-> spi_cs_n);
    // R7
    cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |=> config_error);
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R9
    overrun_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (overrun >= $past(overrun)));
    // R10
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);
endmodule

// File: tb/adc_seq_host_bench.sv
`timescale 1ns/1ps
module adc_seq_host_bench;
    localparam int CLK_HZ = 1_000_000, MOD_DIV = 1, TCSSC = 3, TSCCS = 2;
    localparam int NCFG = 3;
    localparam int PWR = (CLK_HZ / 10000) * 22;
    localparam int RSTW = 4096 * MOD_DIV;
    localparam logic [4:0] BASE = 5'h02;
    // {adc word driven by the model, expected result}
    localparam logic [31:0] VEC [4] = '{32'h0000_0000, 32'hFFFF_FFFF,
                                        32'hA55A_A55A, 32'h8001_8001};

    logic clk = 0, rst_n = 0, start_req = 0, stop_req = 0, drdy_n = 1, miso = 0;
    logic [NCFG*8-1:0] cfg = 24'h3C_91_A7;
    logic busy, rv, cerr, cs_n, sclk, mosi;
    logic [15:0] res;
    logic [7:0] ovr;
    int errors = 0, checks = 0, cyc = 0, rst_c = 0, rv_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_seq_host #(.CLK_HZ(CLK_HZ), .MOD_DIV(MOD_DIV), .TCSSC_CYC(TCSSC),
        .TSCCS_CYC(TSCCS), .SCLK_HALF(2), .NUM_CFG(NCFG), .CFG_BASE(BASE),
        .STAT_CHECK(1'b1), .OVR_W(8)) u_adc_seq_host (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .cfg_data(cfg), .busy(busy), .result_valid(rv), .result(res),
        .config_error(cerr), .overrun(ovr), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .adc_drdy_n(drdy_n));

    // ---------------- converter model ----------------
    logic [7:0] regs [0:31];
    logic [7:0] fr_b [0:63][0:15];
    int fr_len [0:63], fr_st [0:63], fr_en [0:63];
    int fr_cnt = 0, bitn = 0, bytek = 0, nrdy_left = 2;
    logic [7:0] cmd = 0, rxb = 0;
    logic [15:0] adc_val = 0;
    bit corrupt = 0, in_fr = 0;

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 8'h00;
        regs[1] = 8'h80;
    end

    function automatic logic [7:0] out_byte(int k);
        logic [7:0] r;
        r = 8'h00;
        if (cmd == 8'h12 && k == 1) r = adc_val[15:8];
        if (cmd == 8'h12 && k == 2) r = adc_val[7:0];
        if (cmd[7:5] == 3'b001 && k >= 2) begin
            r = regs[5'(cmd[4:0] + 5'(k - 2))];
            if (cmd[4:0] == 5'h01 && nrdy_left > 0) r = r | 8'h40;
            if (corrupt && k == 2 && cmd[4:0] == BASE) r = r ^ 8'h01;
        end
        return r;
    endfunction

    always @(negedge cs_n) if (cs_n === 1'b0) begin
        in_fr = 1; bitn = 0; bytek = 0; fr_st[fr_cnt] = cyc;
    end
    always @(posedge cs_n) if (in_fr) begin
        in_fr = 0;
        fr_len[fr_cnt] = bytek; fr_en[fr_cnt] = cyc;
        if (fr_b[fr_cnt][0] == 8'h21 && nrdy_left > 0) nrdy_left--;
        if (fr_cnt < 63) fr_cnt++;
    end
    always @(posedge sclk) if (in_fr) miso <= out_byte(bytek)[7 - bitn];
    always @(negedge sclk) if (in_fr && cs_n === 1'b0) begin
        rxb = {rxb[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
            fr_b[fr_cnt][bytek] = rxb;
            if (bytek == 0) cmd = rxb;
            if (bytek >= 2 && cmd[7:5] == 3'b010) regs[5'(cmd[4:0] + 5'(bytek - 2))] = rxb;
            bytek++; bitn = 0;
        end
    end

    // ---------------- timing monitor (R2, R12) ----------------
    logic p_cs = 1, p_sclk = 0, p_mosi = 0;
    int viol_t = 0, viol_m = 0, fall_c = 0, last_f = 0;
    bit first = 0;
    always @(negedge clk) if (rst_n) begin
        if (!cs_n && p_cs) begin fall_c = cyc; first = 1; end
        if (sclk && !p_sclk && first) begin
            if (cyc - fall_c < TCSSC) viol_t++;
            first = 0;
        end
        if (!sclk && p_sclk) last_f = cyc;
        if (cs_n && !p_cs && cyc - last_f < TSCCS) viol_t++;
        if (cs_n && sclk) viol_m++;
        if (sclk && p_sclk && mosi != p_mosi) viol_m++;
        if (rv) rv_cnt++;
        p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_frame(input string req, input int n, input int len,
                             input logic [7:0] b0, input logic [7:0] b1);
        chk(req, 32'(fr_len[n]), 32'(len));
        chk(req, {24'h0, fr_b[n][0]}, {24'h0, b0});
        if (len > 1) chk(req, {24'h0, fr_b[n][1]}, {24'h0, b1});
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < 20000 && fr_cnt < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1; @(negedge clk); s = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    // ---------------- stimulus ----------------
    initial begin
        int rv0, fc0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 1); chk("R1 cs_n", 32'(cs_n), 1);
        chk("R1 valid", 32'(rv), 0); chk("R1 cfgerr", 32'(cerr), 0);
        chk("R1 overrun", 32'(ovr), 0);
        rst_n = 1; rst_c = cyc;
        wait_idle();
        chk("R1 power wait", 32'(fr_st[0] - rst_c >= PWR), 1);
        chk_frame("R3 reset cmd", 0, 1, 8'h06, 8'h00);
        chk("R3 reset gap", 32'(fr_st[1] - fr_en[0] >= RSTW), 1);
        for (int i = 1; i <= 3; i++) chk_frame("R4 status read", i, 3, 8'h21, 8'h00);
        chk_frame("R4 status clear", 4, 3, 8'h41, 8'h00);
        chk("R4 status cleared", {24'h0, regs[1]}, 0);
        chk("R5 ready idle", 32'(busy), 0);

        pulse(start_req);
        wait_frames(8);
        chk_frame("R5 cfg write", 5, 5, {3'b010, BASE}, 8'(NCFG - 1));
        chk("R5 cfg bytes", {8'h0, regs[BASE + 2], regs[BASE + 1], regs[BASE]}, {8'h0, cfg});
        chk_frame("R6 readback", 6, 5, {3'b001, BASE}, 8'(NCFG - 1));
        chk_frame("R6 start", 7, 1, 8'h08, 8'h00);
        repeat (20) @(negedge clk);

        // R8: vector table walked by one loop
        foreach (VEC[v]) begin
            rv0 = rv_cnt;
            adc_val = VEC[v][31:16];
            drdy_n = 0; repeat (3) @(negedge clk); drdy_n = 1;
            for (int i = 0; i < 2000 && !rv; i++) @(negedge clk);
            chk("R8 result", {16'h0, res}, {16'h0, VEC[v][15:0]});
            @(negedge clk);
            chk("R8 one-cycle valid", 32'(rv), 0);
            wait_frames(9 + v);
            chk_frame("R8 rdata frame", 8 + v, 3, 8'h12, 8'h00);
            chk("R8 valid count", 32'(rv_cnt - rv0), 1);
            repeat (20) @(negedge clk);
        end

        // R5: start_req while streaming is ignored
        pulse(start_req);
        repeat (200) @(negedge clk);
        chk("R5 start ignored", 32'(fr_cnt), 12);

        // R9: second data-ready edge during a fetch
        rv0 = rv_cnt;
        adc_val = 16'h1234;
        drdy_n = 0; repeat (3) @(negedge clk); drdy_n = 1;
        for (int i = 0; i < 200 && cs_n; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        drdy_n = 0; repeat (3) @(negedge clk); drdy_n = 1;
        wait_frames(13);
        repeat (100) @(negedge clk);
        chk("R9 overrun", 32'(ovr), 1);
        chk("R9 no extra frame", 32'(fr_cnt), 13);
        chk("R9 one result", 32'(rv_cnt - rv0), 1);
        chk("R9 result", {16'h0, res}, 32'h1234);

        // R11: stop and data-ready edge reach the sequencer together
        rv0 = rv_cnt;
        drdy_n = 0; @(negedge clk); @(negedge clk);
        stop_req = 1; @(negedge clk); stop_req = 0;
        wait_idle();
        drdy_n = 1;
        chk_frame("R11 stop wins", 13, 1, 8'h0A, 8'h00);
        chk("R11 no result", 32'(rv_cnt - rv0), 0);
        chk("R11 overrun held", 32'(ovr), 1);
        chk("R10 idle after stop", 32'(busy), 0);

        // R10: restart then plain stop
        pulse(start_req);
        wait_frames(17);
        chk_frame("R10 restart", 16, 1, 8'h08, 8'h00);
        repeat (20) @(negedge clk);
        pulse(stop_req);
        wait_idle();
        chk_frame("R10 stop", 17, 1, 8'h0A, 8'h00);
        chk("R10 busy low", 32'(busy), 0);

        // R7: readback mismatch
        corrupt = 1;
        pulse(start_req);
        wait_idle();
        repeat (50) @(negedge clk);
        chk("R7 config_error", 32'(cerr), 1);
        chk("R7 no start frame", 32'(fr_cnt), 20);
        chk_frame("R7 readback sent", 19, 5, {3'b001, BASE}, 8'(NCFG - 1));
        fc0 = fr_cnt;
        pulse(start_req);
        repeat (300) @(negedge clk);
        chk("R7 start blocked", 32'(fr_cnt), 32'(fc0));
        chk("R7 still idle", 32'(busy), 0);
        chk("R7 sticky", 32'(cerr), 1);

        // R2 / R12 monitor totals
        chk("R2 mode-1 violations", 32'(viol_m), 0);
        chk("R12 cs timing violations", 32'(viol_t), 0);
        summary();
    end
endmodule